// File: doc/BRIEF.md
# Packed Floating-Point Compare Mask Unit

This block compares two 128-bit vector registers lane by lane. It treats them as IEEE-754 values: either four single-precision lanes or two double-precision lanes. A 3-bit code selects one of eight relational tests. Each lane of the result becomes an all-ones mask when the test holds and an all-zeros mask when it does not. Software then uses these masks for branch-free selection with bitwise logic.

In packed mode the unit writes every lane. In scalar mode it evaluates only the lowest lane, and the rest of the result is a copy of the first operand. The unit also keeps a sticky flag that records any NaN operand it has seen in an evaluated lane. The result is registered, so it appears one clock after the request.

Top module: `simd_cmp_mask`

## Requirements
- R1: When `in_valid` is high at a rising edge, the result and `res_valid` appear after that edge. With `in_valid` low, `res_valid` is 0 and `res_out` holds its value. Synchronous `rst` clears `res_out`, `res_valid` and `invalid_flag` to 0.
- R2: The `pred` code selects the test: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered. A lane is all ones when the test holds and all zeros otherwise.
- R3: A NaN has an all-ones exponent and a nonzero fraction. Equal, less-than and less-or-equal are false when either lane operand is a NaN.
- R4: Codes 4, 5 and 6 are the exact complements of codes 0, 1 and 2, so they give all ones for an unordered lane pair.
- R5: Unordered gives all ones when at least one operand is a NaN. Ordered gives all ones only when neither operand is a NaN.
- R6: +0 and -0 compare equal. Other ordered values follow the sign-magnitude order of their encodings, so -inf is the smallest value and +inf the largest.
- R7: With `dbl_sel`=0 the lanes are 32 bits wide, and lane k occupies bits [32k+31:32k]. With `dbl_sel`=1 the lanes are 64 bits wide, and lane k occupies bits [64k+63:64k]. Lane a-operand is `dst_in`, b-operand is `src_in`.
- R8: With `scalar_sel`=1 only lane 0 is evaluated. All bits above lane 0 are copied from `dst_in`.
- R9: `invalid_flag` is set when an evaluated lane has a NaN operand. It stays set until reset. The lane results are still written. NaNs in lanes that are not evaluated do not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| pred | input | 3 | Test code |
| dbl_sel | input | 1 | 1 = 64-bit lanes, 0 = 32-bit lanes |
| scalar_sel | input | 1 | 1 = lane 0 only |
| dst_in | input | 128 | First operand and pass-through source |
| src_in | input | 128 | Second operand |
| res_out | output | 128 | Registered mask result |
| res_valid | output | 1 | Result strobe |
| invalid_flag | output | 1 | Sticky NaN indicator |

## Verification
Every result passes through a single register stage. A fault in lane decoding or test selection therefore shows up on `res_out` in the very next cycle. It appears either as a lane that is neither all ones nor all zeros, or as a mask with the wrong polarity on NaN, zero or infinity operands. A faulty scalar pass-through corrupts the upper lanes of that same result. A stuck or self-clearing sticky flag shows up on `invalid_flag` within one cycle of the first NaN request, or at the next reset.

// File: rtl/simd_cmp_pkg.sv
package simd_cmp_pkg;

  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_LT    = 3'd1,
    PRED_LE    = 3'd2,
    PRED_UNORD = 3'd3,
    PRED_NEQ   = 3'd4,
    PRED_NLT   = 3'd5,
    PRED_NLE   = 3'd6,
    PRED_ORD   = 3'd7
  } pred_e;

  // Low two bits pick the base relation, the top bit inverts it.
  function automatic logic pred_apply(pred_e p, logic eq, logic lt,
                                      logic le, logic un);
    logic base;
    case (p[1:0])
      2'd0:    base = eq;
      2'd1:    base = lt;
      2'd2:    base = le;
      default: base = un;
    endcase
    return base ^ p[2];
  endfunction

endpackage

// File: rtl/fp_lane_rel.sv
module fp_lane_rel #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         lt,
  output logic         le,
  output logic         unord
);
  logic a_nan, b_nan, both_zero, a_s, b_s, mag_lt, mag_gt, raw_lt;

  always_comb begin
    a_s   = a[W-1];
    b_s   = b[W-1];
    a_nan = (&a[W-2:MAN_W]) && (|a[MAN_W-1:0]);
    b_nan = (&b[W-2:MAN_W]) && (|b[MAN_W-1:0]);
    unord = a_nan | b_nan;
    both_zero = (a[W-2:0] == '0) && (b[W-2:0] == '0);
    mag_lt = a[W-2:0] < b[W-2:0];
    mag_gt = a[W-2:0] > b[W-2:0];
    if (both_zero)         raw_lt = 1'b0;
    else if (a_s != b_s)   raw_lt = a_s;
    else if (a_s)          raw_lt = mag_gt;
    else                   raw_lt = mag_lt;
    eq = !unord && ((a == b) || both_zero);
    lt = !unord && raw_lt;
    le = lt | eq;
  end
endmodule

// File: rtl/lane_mask_gen.sv
module lane_mask_gen
  import simd_cmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  pred_e        code,
  output logic [W-1:0] mask,
  output logic         nan_seen
);
  logic eq, lt, le, un;

  fp_lane_rel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
    .a(a), .b(b), .eq(eq), .lt(lt), .le(le), .unord(un)
  );

  always_comb begin
    mask     = {W{pred_apply(code, eq, lt, le, un)}};
    nan_seen = un;
  end
endmodule

// File: rtl/simd_cmp_mask.sv
module simd_cmp_mask
  import simd_cmp_pkg::*;
#(
  parameter int REG_W  = 128,
  parameter int SP_EXP = 8,
  parameter int SP_MAN = 23,
  parameter int DP_EXP = 11,
  parameter int DP_MAN = 52
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       pred,
  input  logic             dbl_sel,
  input  logic             scalar_sel,
  input  logic [REG_W-1:0] dst_in,
  input  logic [REG_W-1:0] src_in,
  output logic [REG_W-1:0] res_out,
  output logic             res_valid,
  output logic             invalid_flag
);
  localparam int SP_W     = 1 + SP_EXP + SP_MAN;
  localparam int DP_W     = 1 + DP_EXP + DP_MAN;
  localparam int SP_LANES = REG_W / SP_W;
  localparam int DP_LANES = REG_W / DP_W;

  pred_e                code;
  logic [REG_W-1:0]     sp_mask, dp_mask, next_res;
  logic [SP_LANES-1:0]  sp_nan;
  logic [DP_LANES-1:0]  dp_nan;
  logic                 next_nan;

  assign code = pred_e'(pred);

  for (genvar g = 0; g < SP_LANES; g++) begin : g_sp
    lane_mask_gen #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_lane (
      .a(dst_in[g*SP_W +: SP_W]), .b(src_in[g*SP_W +: SP_W]), .code(code),
      .mask(sp_mask[g*SP_W +: SP_W]), .nan_seen(sp_nan[g])
    );
  end

  for (genvar g = 0; g < DP_LANES; g++) begin : g_dp
    lane_mask_gen #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_lane (
      .a(dst_in[g*DP_W +: DP_W]), .b(src_in[g*DP_W +: DP_W]), .code(code),
      .mask(dp_mask[g*DP_W +: DP_W]), .nan_seen(dp_nan[g])
    );
  end

  always_comb begin
    case ({dbl_sel, scalar_sel})
      2'b00: begin next_res = sp_mask; next_nan = |sp_nan; end
      2'b01: begin
        next_res = {dst_in[REG_W-1:SP_W], sp_mask[SP_W-1:0]};
        next_nan = sp_nan[0];
      end
      2'b10: begin next_res = dp_mask; next_nan = |dp_nan; end
      default: begin
        next_res = {dst_in[REG_W-1:DP_W], dp_mask[DP_W-1:0]};
        next_nan = dp_nan[0];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_out      <= '0;
      res_valid    <= 1'b0;
      invalid_flag <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_out <= next_res;
        if (next_nan) invalid_flag <= 1'b1;
      end
    end
  end

  // Assertions
  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && $stable(res_out)));

  for (genvar k = 0; k < SP_LANES; k++) begin : g_chk
    p_lane_mask_r2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !scalar_sel) |=>
        (res_out[k*SP_W +: SP_W] == '0 || res_out[k*SP_W +: SP_W] == '1));
  end

  p_dp_halves_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !scalar_sel && dbl_sel) |=>
      (res_out[DP_W-1:DP_W-SP_W] == res_out[SP_W-1:0]));

  p_scalar_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar_sel) |=>
      (res_out[REG_W-1:DP_W] == $past(dst_in[REG_W-1:DP_W])));

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    invalid_flag |=> invalid_flag);
endmodule

// File: tb/test_simd_cmp_mask.sv
`timescale 1ns/1ps
module test_simd_cmp_mask;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [2:0]   pred;
  logic         dbl_sel, scalar_sel;
  logic [127:0] dst_in, src_in, res_out;
  logic         res_valid, invalid_flag;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  simd_cmp_mask i_simd_cmp_mask (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pred(pred),
    .dbl_sel(dbl_sel), .scalar_sel(scalar_sel), .dst_in(dst_in),
    .src_in(src_in), .res_out(res_out), .res_valid(res_valid),
    .invalid_flag(invalid_flag)
  );

  localparam logic [31:0] ONE = 32'h3F800000, TWO = 32'h40000000,
    MONE = 32'hBF800000, PZ = 32'h00000000, NZ = 32'h80000000,
    QN = 32'h7FC00000, PINF = 32'h7F800000, NINF = 32'hFF800000,
    T = 32'hFFFFFFFF, F = 32'h00000000;
  localparam logic [63:0] D1 = 64'h3FF0000000000000,
    D2 = 64'h4000000000000000, DM2 = 64'hC000000000000000,
    DN = 64'h7FF8000000000000, DT = '1, DF = '0;

  // {pred, dbl, scalar, dst, src, expected}; lanes written lane3..lane0
  localparam int NV = 12;
  localparam logic [388:0] TBL [NV] = '{
    {3'd0,1'b0,1'b0,{ONE,TWO,PZ,QN},{ONE,ONE,NZ,QN},{T,F,T,F}},        // R2 R3 R6 EQ
    {3'd1,1'b0,1'b0,{MONE,ONE,PZ,NINF},{ONE,ONE,NZ,ONE},{T,F,F,T}},    // R6 LT
    {3'd2,1'b0,1'b0,{TWO,ONE,MONE,QN},{ONE,ONE,NZ,ONE},{F,T,T,F}},     // R3 LE
    {3'd3,1'b0,1'b0,{QN,ONE,PINF,ONE},{ONE,QN,PINF,ONE},{T,T,F,F}},    // R5 UNORD
    {3'd4,1'b0,1'b0,{ONE,QN,PZ,TWO},{ONE,ONE,NZ,ONE},{F,T,F,T}},       // R4 NEQ
    {3'd5,1'b0,1'b0,{MONE,QN,TWO,ONE},{ONE,TWO,ONE,ONE},{F,T,T,T}},    // R4 NLT
    {3'd6,1'b0,1'b0,{TWO,ONE,QN,MONE},{ONE,ONE,ONE,NINF},{T,F,T,T}},   // R4 NLE
    {3'd7,1'b0,1'b0,{ONE,QN,PINF,NZ},{QN,ONE,NINF,PZ},{F,F,T,T}},      // R5 ORD
    {3'd1,1'b1,1'b0,{DM2,DN},{D1,D1},{DT,DF}},                         // R7 dp LT
    {3'd0,1'b1,1'b0,{D1,D2},{D1,D1},{DT,DF}},                          // R7 dp EQ
    {3'd1,1'b0,1'b1,{32'hAAAAAAAA,32'hBBBBBBBB,32'hCCCCCCCC,MONE},
                    {QN,QN,QN,ONE},{32'hAAAAAAAA,32'hBBBBBBBB,32'hCCCCCCCC,T}}, // R8 sp
    {3'd6,1'b1,1'b1,{64'h0123456789ABCDEF,D1},{DN,D2},{64'h0123456789ABCDEF,DF}} // R8 dp
  };

  task automatic check(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] p, input logic d, input logic s,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    pred = p; dbl_sel = d; scalar_sel = s; dst_in = a; src_in = b;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] held;
    rst = 1'b1; in_valid = 1'b0; pred = '0; dbl_sel = 1'b0;
    scalar_sel = 1'b0; dst_in = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset res_out", res_out, '0);
    check("R1 reset res_valid", {127'd0, res_valid}, 128'd1 - 128'd1);
    check("R1 reset invalid_flag", {127'd0, invalid_flag}, '0);

    // R8 R9: NaNs only in unevaluated lanes leave the flag clear
    issue(3'd0, 1'b0, 1'b1, {TWO, TWO, TWO, ONE}, {QN, QN, QN, ONE});
    check("R8 scalar pass-through", res_out, {TWO, TWO, TWO, T});
    check("R1 res_valid after request", {127'd0, res_valid}, 128'd1);
    check("R9 no flag from upper lanes", {127'd0, invalid_flag}, '0);

    // R1 hold with idle input
    held = res_out;
    @(negedge clk);
    dst_in = '1; src_in = '0; pred = 3'd7;
    @(negedge clk);
    check("R1 hold res_out", res_out, held);
    check("R1 idle res_valid", {127'd0, res_valid}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [388:0] v;
      v = TBL[i];
      issue(v[388:386], v[385], v[384], v[383:256], v[255:128]);
      check($sformatf("R2 table row %0d", i), res_out, v[127:0]);
      check($sformatf("R1 table row %0d valid", i), {127'd0, res_valid}, 128'd1);
    end
    // R9: flag set by NaN rows and stays set
    check("R9 sticky set", {127'd0, invalid_flag}, 128'd1);
    repeat (3) @(negedge clk);
    check("R9 sticky held", {127'd0, invalid_flag}, 128'd1);

    // R1 R9 reset clears flag
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 cleared by reset", {127'd0, invalid_flag}, '0);
    check("R1 reset clears res_out", res_out, '0);

    // R9 results still written on NaN; R3 double precision NaN
    issue(3'd4, 1'b1, 1'b0, {DN, D1}, {D1, D1});
    check("R9 NaN result written", res_out, {DT, DF});
    check("R9 flag set packed dp", {127'd0, invalid_flag}, 128'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule